// File: doc/BRIEF.md
# I2C Data FIFO with Thresholds

This block sits between a host-side byte data port and an I2C byte engine. It holds one byte queue for transmit (host writes, engine takes) and one for receive (engine deposits, host reads). Each direction has a programmable threshold. A ready flag tells the host or a DMA engine that a whole threshold-sized chunk can be moved in one go. A separate drain flag covers the end of a transfer, when fewer bytes than the threshold remain. In that case the level fields tell the mover exactly how many bytes make up the last partial chunk.

A 16-bit configuration word sets the two thresholds and the two DMA request enables. It also has a self-clearing flush control for each queue. A 16-bit status word reports both occupancy levels and a fixed depth code. The remaining-byte count of the current transfer comes from an external transfer counter and feeds the drain logic. The engine side gets an overrun pulse when it pushes into a full receive queue. It gets an underflow pulse when it asks an empty transmit queue for data while the transfer still has bytes to move.

Top module: `i2c_data_fifo`

## Requirements
- R1: After reset both levels are 0, the configuration word reads 0 (both thresholds 1), transmit ready is 1, and receive ready, both drain flags and both error pulses are 0.
- R2: The configuration word holds these fields: receive DMA enable in bit 15, receive flush in bit 14, receive threshold minus one in bits [13:8], transmit DMA enable in bit 7, transmit flush in bit 6, and transmit threshold minus one in bits [5:0]. A write is visible on the read-back port after the write edge, and the two DMA bits drive the DMA enable outputs.
- R3: Each queue returns bytes in the order they entered. The status word shows the receive level in bits [13:8] and the transmit level in bits [5:0], updated after the edge that moves a byte.
- R4: Receive ready is 1 exactly when the receive level is at least the receive threshold. The threshold is the field plus one, clamped to the depth.
- R5: Transmit ready is 1 exactly when the free transmit space (depth minus level) is at least the transmit threshold, clamped in the same way.
- R6: Receive drain is 1 when the remaining count is 0 and the receive level is nonzero but below the receive threshold.
- R7: Transmit drain is 1 when the remaining count is nonzero, below the transmit threshold, and larger than the transmit level.
- R8: Writing 1 to a flush bit sets it at the write edge. The queue is emptied at the next edge, and the bit reads back 0 after one further edge. Bytes pushed after the emptying edge are kept.
- R9: A host write to a full transmit queue is ignored: the level stays at the depth and the stored bytes come out unchanged.
- R10: An engine push into a full receive queue drops the byte and raises the receive overrun output for exactly the one cycle after that edge.
- R11: An engine pop from an empty transmit queue raises the transmit underflow output for the one cycle after that edge when the remaining count is nonzero, and does not raise it when the count is 0.
- R12: Status bits [15:14] hold the depth code s, and the queue depth is 8 shifted left by s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word write value |
| cfg_rdata | output | 16 | Configuration word read-back |
| stat | output | 16 | Status word: depth code, receive level, transmit level |
| tx_we | input | 1 | Host byte write into the transmit queue |
| tx_wdata | input | 8 | Host byte to transmit |
| rx_re | input | 1 | Host byte read from the receive queue |
| rx_rdata | output | 8 | Oldest byte in the receive queue |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Oldest byte in the transmit queue |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte from the engine |
| xfer_remain | input | CNT_W | Bytes remaining in the current transfer |
| rx_ready | output | 1 | A full receive threshold can be read |
| tx_ready | output | 1 | A full transmit threshold can be written |
| rx_drain | output | 1 | Residual receive chunk below threshold |
| tx_drain | output | 1 | Residual transmit chunk below threshold |
| rx_overrun | output | 1 | One-cycle pulse: push into a full receive queue |
| tx_underflow | output | 1 | One-cycle pulse: pop from an empty transmit queue mid-transfer |
| rx_dma_en | output | 1 | Receive DMA enable |
| tx_dma_en | output | 1 | Transmit DMA enable |

## Verification
Levels, configuration read-back and stored bytes change at the clock edge that applies a strobe. The ready and drain flags follow combinationally from those registers and from the remaining count, so the bench checks all of them one time unit after that edge. The overrun and underflow pulses are registered. They are sampled just after the offending edge, and then again one edge later to confirm they have dropped. A flush spans three edges: the bit is set at the write edge, the queue empties at the next edge, and the bit drops at the edge after that. The bench samples after each of these three edges, so a shift by one cycle in either direction is caught.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
   localparam int FIELD_W     = 6;
   localparam int THR_W       = 8;
   // configuration bit positions (read by software, so fixed)
   localparam int TX_THR_LSB  = 0;
   localparam int TX_CLR_BIT  = 6;
   localparam int TX_DMA_BIT  = 7;
   localparam int RX_THR_LSB  = 8;
   localparam int RX_CLR_BIT  = 14;
   localparam int RX_DMA_BIT  = 15;

   // effective threshold: programmed field plus one, never beyond the depth
   function automatic logic [THR_W-1:0] eff_thr(input logic [FIELD_W-1:0] m1,
                                                input logic [THR_W-1:0]   depth);
      logic [THR_W-1:0] t;
      t = {{(THR_W-FIELD_W){1'b0}}, m1} + THR_W'(1);
      return (t > depth) ? depth : t;
   endfunction
endpackage

// File: rtl/i2c_fifo_store.sv
module i2c_fifo_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DW-1:0]     push_data,
   input  logic              pop,
   output logic [DW-1:0]     pop_data,
   output logic [$clog2(DEPTH):0] level,
   output logic              full,
   output logic              empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = AW + 1;

   if ((1 << AW) != DEPTH) begin : g_depth_chk
      $error("i2c_fifo_store: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full     = (level == LW'(DEPTH));
   assign empty    = (level == '0);
   assign do_push  = push && !full && !flush;
   assign do_pop   = pop && !empty && !flush;
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   p_full_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (level == LW'(DEPTH)));
   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/i2c_fifo_watermark.sv
module i2c_fifo_watermark
   import i2c_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 16,
   parameter bit IS_RX = 1'b1
) (
   input  logic [FIELD_W-1:0]      thr_m1,
   input  logic [$clog2(DEPTH):0]  level,
   input  logic [CNT_W-1:0]        remain,
   output logic                    ready,
   output logic                    drain
);
   localparam logic [THR_W-1:0] DEPTH_T = THR_W'(DEPTH);

   logic [THR_W-1:0] thr;
   logic [THR_W-1:0] lvl;

   assign thr = eff_thr(thr_m1, DEPTH_T);
   assign lvl = THR_W'(level);

   if (IS_RX) begin : g_rx
      // bytes waiting to be read
      assign ready = (lvl >= thr);
      assign drain = (remain == '0) && (lvl != '0) && (lvl < thr);
   end else begin : g_tx
      logic [THR_W-1:0] space;
      assign space = DEPTH_T - lvl;
      assign ready = (space >= thr);
      assign drain = (remain != '0) && (remain < CNT_W'(thr)) &&
                     (remain > CNT_W'(lvl));
   end
endmodule

// File: rtl/i2c_fifo_clr_ctl.sv
module i2c_fifo_clr_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   output logic pending,
   output logic flush
);
   logic done;

   // set at the write edge, flush at the next, drop at the one after
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         done    <= 1'b0;
      end else if (set) begin
         pending <= 1'b1;
         done    <= 1'b0;
      end else if (pending && !done) begin
         done    <= 1'b1;
      end else if (pending) begin
         pending <= 1'b0;
         done    <= 1'b0;
      end
   end

   assign flush = pending && !done;

   p_flush_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !set) |=> !flush);
   p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !flush && !set) |=> !pending);
endmodule

// File: rtl/i2c_data_fifo.sv
module i2c_data_fifo
   import i2c_fifo_pkg::*;
#(
   parameter int DEPTH_CODE = 1,
   parameter int CNT_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [15:0]      cfg_wdata,
   output logic [15:0]      cfg_rdata,
   output logic [15:0]      stat,
   input  logic             tx_we,
   input  logic [7:0]       tx_wdata,
   input  logic             rx_re,
   output logic [7:0]       rx_rdata,
   input  logic             eng_tx_pop,
   output logic [7:0]       eng_tx_byte,
   input  logic             eng_rx_push,
   input  logic [7:0]       eng_rx_byte,
   input  logic [CNT_W-1:0] xfer_remain,
   output logic             rx_ready,
   output logic             tx_ready,
   output logic             rx_drain,
   output logic             tx_drain,
   output logic             rx_overrun,
   output logic             tx_underflow,
   output logic             rx_dma_en,
   output logic             tx_dma_en
);
   localparam int DEPTH = 8 << DEPTH_CODE;
   localparam int LW    = $clog2(DEPTH) + 1;

   if (DEPTH_CODE < 0 || DEPTH_CODE > 2) begin : g_code_chk
      $error("i2c_data_fifo: DEPTH_CODE must be 0..2 so a level fits its field");
   end
   if (CNT_W < THR_W) begin : g_cnt_chk
      $error("i2c_data_fifo: CNT_W too narrow for threshold compare");
   end

   // configuration fields
   logic [FIELD_W-1:0] rx_thr_m1, tx_thr_m1;
   logic               rx_dma_q, tx_dma_q;
   logic [1:0]         clr_pend, clr_flush;   // index 0 transmit, 1 receive

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_thr_m1 <= '0;
         tx_thr_m1 <= '0;
         rx_dma_q  <= 1'b0;
         tx_dma_q  <= 1'b0;
      end else if (cfg_we) begin
         rx_thr_m1 <= cfg_wdata[RX_THR_LSB +: FIELD_W];
         tx_thr_m1 <= cfg_wdata[TX_THR_LSB +: FIELD_W];
         rx_dma_q  <= cfg_wdata[RX_DMA_BIT];
         tx_dma_q  <= cfg_wdata[TX_DMA_BIT];
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_clr
      localparam int POS = (g == 0) ? TX_CLR_BIT : RX_CLR_BIT;
      i2c_fifo_clr_ctl u_clr (
         .clk     (clk),
         .rst_n   (rst_n),
         .set     (cfg_we && cfg_wdata[POS]),
         .pending (clr_pend[g]),
         .flush   (clr_flush[g])
      );
   end

   assign cfg_rdata = {rx_dma_q, clr_pend[1], rx_thr_m1,
                       tx_dma_q, clr_pend[0], tx_thr_m1};
   assign rx_dma_en = rx_dma_q;
   assign tx_dma_en = tx_dma_q;

   // queues
   logic [LW-1:0] tx_lvl, rx_lvl;
   logic          tx_full, tx_empty, rx_full, rx_empty;

   i2c_fifo_store #(.DEPTH(DEPTH), .DW(8)) u_tx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (clr_flush[0]),
      .push      (tx_we),
      .push_data (tx_wdata),
      .pop       (eng_tx_pop),
      .pop_data  (eng_tx_byte),
      .level     (tx_lvl),
      .full      (tx_full),
      .empty     (tx_empty)
   );

   i2c_fifo_store #(.DEPTH(DEPTH), .DW(8)) u_rx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (clr_flush[1]),
      .push      (eng_rx_push),
      .push_data (eng_rx_byte),
      .pop       (rx_re),
      .pop_data  (rx_rdata),
      .level     (rx_lvl),
      .full      (rx_full),
      .empty     (rx_empty)
   );

   // threshold flags
   i2c_fifo_watermark #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b1)) u_rx_wm (
      .thr_m1 (rx_thr_m1),
      .level  (rx_lvl),
      .remain (xfer_remain),
      .ready  (rx_ready),
      .drain  (rx_drain)
   );

   i2c_fifo_watermark #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b0)) u_tx_wm (
      .thr_m1 (tx_thr_m1),
      .level  (tx_lvl),
      .remain (xfer_remain),
      .ready  (tx_ready),
      .drain  (tx_drain)
   );

   // error pulses, one cycle after the offending edge
   logic ovr_q, udf_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         ovr_q <= eng_rx_push && rx_full;
         udf_q <= eng_tx_pop && tx_empty && (xfer_remain != '0);
      end
   end
   assign rx_overrun   = ovr_q;
   assign tx_underflow = udf_q;

   assign stat = {2'(DEPTH_CODE), FIELD_W'(rx_lvl), 2'b00, FIELD_W'(tx_lvl)};

   p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rx_full) |=> rx_overrun);
   p_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_pop && tx_empty && xfer_remain != '0) |=> tx_underflow);
   p_full_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full |-> !tx_ready);
   p_drain_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drain |-> (!rx_ready && !rx_empty));
endmodule

// File: tb/i2c_data_fifo_tb.sv
module i2c_data_fifo_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata, stat;
   logic        tx_we = 1'b0;
   logic [7:0]  tx_wdata = '0;
   logic        rx_re = 1'b0;
   logic [7:0]  rx_rdata;
   logic        eng_tx_pop = 1'b0;
   logic [7:0]  eng_tx_byte;
   logic        eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_byte = '0;
   logic [15:0] xfer_remain = '0;
   logic        rx_ready, tx_ready, rx_drain, tx_drain;
   logic        rx_overrun, tx_underflow, rx_dma_en, tx_dma_en;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   i2c_data_fifo #(.DEPTH_CODE(1), .CNT_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .stat(stat), .tx_we(tx_we), .tx_wdata(tx_wdata),
      .rx_re(rx_re), .rx_rdata(rx_rdata), .eng_tx_pop(eng_tx_pop),
      .eng_tx_byte(eng_tx_byte), .eng_rx_push(eng_rx_push),
      .eng_rx_byte(eng_rx_byte), .xfer_remain(xfer_remain),
      .rx_ready(rx_ready), .tx_ready(tx_ready), .rx_drain(rx_drain),
      .tx_drain(tx_drain), .rx_overrun(rx_overrun),
      .tx_underflow(tx_underflow), .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one edge, then settle away from it
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic cfg_write(input logic [15:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic host_tx(input logic [7:0] b);
      tx_we = 1'b1; tx_wdata = b;
      step();
      tx_we = 1'b0;
   endtask

   task automatic eng_rx(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_byte = b;
      step();
      eng_rx_push = 1'b0;
   endtask

   task automatic eng_take(input string req, input logic [7:0] exp);
      chk(req, eng_tx_byte, exp);
      eng_tx_pop = 1'b1;
      step();
      eng_tx_pop = 1'b0;
   endtask

   task automatic host_read(input string req, input logic [7:0] exp);
      chk(req, rx_rdata, exp);
      rx_re = 1'b1;
      step();
      rx_re = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12 depth code", stat[15:14], 1);
      chk("R1 status", stat, 16'h4000);
      chk("R1 config", cfg_rdata, 0);
      chk("R1 tx_ready", tx_ready, 1);
      chk("R1 rx_ready", rx_ready, 0);
      chk("R1 drains", {rx_drain, tx_drain}, 0);
      chk("R1 pulses", {rx_overrun, tx_underflow}, 0);
   endtask

   task automatic t_cfg();
      cfg_write(16'h8385);   // rx thr 4, tx thr 6, both DMA on
      chk("R2 readback", cfg_rdata, 16'h8385);
      chk("R2 dma enables", {rx_dma_en, tx_dma_en}, 2'b11);
   endtask

   task automatic t_tx_order();
      for (int i = 0; i < 10; i++) host_tx(8'hA0 + 8'(i));
      chk("R5 ready with 6 free", tx_ready, 1);
      host_tx(8'hAA);
      chk("R5 ready with 5 free", tx_ready, 0);
      chk("R3 tx level", stat[5:0], 11);
      for (int i = 0; i < 11; i++) eng_take("R3 tx order", 8'hA0 + 8'(i));
      chk("R3 tx level empty", stat[5:0], 0);
      xfer_remain = 16'd0;
      eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
      chk("R11 no underflow at count 0", tx_underflow, 0);
   endtask

   task automatic t_rx();
      for (int i = 0; i < 3; i++) eng_rx(8'h60 + 8'(i));
      chk("R4 below threshold", rx_ready, 0);
      eng_rx(8'h63);
      chk("R4 at threshold", rx_ready, 1);
      chk("R3 rx level", stat[13:8], 4);
      for (int i = 0; i < 4; i++) host_read("R3 rx order", 8'h60 + 8'(i));
      chk("R3 rx level empty", stat[13:8], 0);
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 16; i++) eng_rx(8'h30 + 8'(i));
      chk("R10 no pulse before overflow", rx_overrun, 0);
      eng_rx(8'hFF);
      chk("R10 overrun pulse", rx_overrun, 1);
      chk("R10 level held", stat[13:8], 16);
      step();
      chk("R10 pulse one cycle", rx_overrun, 0);
      cfg_write(16'h3F05);  // rx field 63 clamps to depth 16
      chk("R4 clamped threshold", rx_ready, 1);
      for (int i = 0; i < 16; i++) host_read("R10 no dropped byte", 8'h30 + 8'(i));
      chk("R4 empty not ready", rx_ready, 0);
   endtask

   task automatic t_tx_full();
      cfg_write(16'h0305);
      for (int i = 0; i < 16; i++) host_tx(8'h10 + 8'(i));
      host_tx(8'hEE);
      chk("R9 level stays at depth", stat[5:0], 16);
      chk("R9 full not ready", tx_ready, 0);
      for (int i = 0; i < 16; i++) eng_take("R9 contents intact", 8'h10 + 8'(i));
      chk("R9 empty after", stat[5:0], 0);
   endtask

   task automatic t_drain();
      eng_rx(8'h71); eng_rx(8'h72);
      xfer_remain = 16'd3; #1;
      chk("R6 no drain mid transfer", rx_drain, 0);
      xfer_remain = 16'd0; #1;
      chk("R6 drain at end", rx_drain, 1);
      chk("R6 residual level", stat[13:8], 2);
      host_read("R6 residual", 8'h71);
      host_read("R6 residual", 8'h72);
      chk("R6 drain off when empty", rx_drain, 0);
      xfer_remain = 16'd4; #1;
      chk("R7 drain on short tail", tx_drain, 1);
      for (int i = 0; i < 4; i++) host_tx(8'h80 + 8'(i));
      chk("R7 drain off when covered", tx_drain, 0);
      xfer_remain = 16'd8; #1;
      chk("R7 no drain above threshold", tx_drain, 0);
      xfer_remain = 16'd0;
      for (int i = 0; i < 4; i++) eng_take("R7 tail bytes", 8'h80 + 8'(i));
   endtask

   task automatic t_underflow();
      xfer_remain = 16'd5;
      eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
      chk("R11 underflow pulse", tx_underflow, 1);
      step();
      chk("R11 pulse one cycle", tx_underflow, 0);
      xfer_remain = 16'd0;
   endtask

   task automatic t_clear();
      host_tx(8'h01); host_tx(8'h02); host_tx(8'h03);
      eng_rx(8'h04); eng_rx(8'h05);
      cfg_write(16'h4345);
      chk("R8 bits set after write", cfg_rdata, 16'h4345);
      chk("R8 levels before flush", {stat[13:8], stat[5:0]}, {6'd2, 6'd3});
      step();
      chk("R8 flushed", {stat[13:8], stat[5:0]}, 0);
      chk("R8 bits still set", cfg_rdata, 16'h4345);
      step();
      chk("R8 bits self-cleared", cfg_rdata, 16'h0305);
      host_tx(8'h5A);
      chk("R8 queue usable", stat[5:0], 1);
      eng_take("R8 new byte", 8'h5A);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_cfg();
      t_tx_order();
      t_rx();
      t_overrun();
      t_tx_full();
      t_drain();
      t_underflow();
      t_clear();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule